// File: doc/BRIEF.md
# Programmable Raster Video Timing Generator

This block produces the horizontal and vertical timing of a raster display. Two 10-bit counters walk across a programmed line length and frame height. From their values the block derives sync pulses, blanking flags and a border decision. A pixel input is passed through inside the programmed display window. Everywhere else the output is a 24-bit border colour.

Software programs the block through a simple register write port and a combinational read port. The block supports:
- interlaced scan with a field indicator;
- progressive scan;
- selectable sync polarity;
- a blank-all override;
- a doubled pixel rate for VGA-style output;
- a line-repeat mode.

Two independent line compare values raise a one-clock interrupt pulse when the beam enters a matching line.

A small sequencer has three states. SEQ_OFF holds the counters at zero while video output is disabled. SEQ_SCAN is the normal pass over a line. SEQ_REPEAT is the second pass of a repeated line. Its transitions are:
- SEQ_OFF to SEQ_SCAN when the enable is set.
- SEQ_SCAN to SEQ_REPEAT at the end of a line when line repeat is on.
- SEQ_REPEAT back to SEQ_SCAN at the end of the repeated line.
- From any state to SEQ_OFF when the enable is cleared.

Top module: `vtg_top`

## Requirements
- R1: Register addresses (3-bit word address) are:
  - 0, control (7 bits).
  - 1, totals: horizontal in [9:0], vertical in [25:16].
  - 2, horizontal window: start [9:0], end [25:16].
  - 3, vertical window: start [9:0], end [25:16].
  - 4, sync widths: horizontal [6:0], vertical [11:8].
  - 5, interrupt lines: A [9:0], B [25:16].
  - 6, border colour [23:0].
  
  Written values read back with unused bits as 0. After reset:
  - control reads 0;
  - the totals are 857 and 524;
  - the windows are 126..837 and 40..520;
  - the sync widths are 63 and 3;
  - the interrupt lines are 21 and 510;
  - the colour is 0.
- R2: Control bits are:
  - bit0 video enable;
  - bit1 interlace;
  - bit2 hsync active-high;
  - bit3 vsync active-high;
  - bit4 blank-all;
  - bit5 pixel-rate double;
  - bit6 line repeat.
  
  While running, the horizontal count advances once every two clocks, or every clock when bit5 is set. The first advance comes on the second running clock. The count wraps to 0 after reaching the horizontal total, so a line has total+1 pixels. The count also wraps when it is at or above the total.
- R3: At each line end the line count advances. It wraps to 0 after reaching the vertical total (or when at or above it), giving total+1 lines per frame.
- R4: With line repeat set, each line is scanned twice. The line count advances only at the end of the second pass.
- R5: Horizontal sync is active while the pixel count is below the horizontal sync width. Vertical sync is active while the line count is below the vertical sync width. Each sync is driven high when active if its polarity bit is 1, and low when active if it is 0.
- R6: hblank is 1 unless the pixel count lies in [start, end) of the horizontal window. vblank is 1 unless the line count lies in [start, end) of the vertical window. The pixel output is pix_in when neither is set, otherwise the border colour.
- R7: With blank-all set, the pixel output is the border colour on every running pixel.
- R8: line_irq pulses for one clock on the first clock of a line whose new line count equals interrupt line A or B. It does not pulse on the second pass of a repeated line. A compare value above the vertical total never produces a pulse.
- R9: With interlace on, the field bit toggles each time the line count wraps to 0. With interlace off, it is held at 0.
- R10: With the enable clear, the sequencer is in SEQ_OFF. In that state:
  - the counters, field and interrupt are 0;
  - both syncs sit at their inactive level;
  - the pixel output is 0.
  
  Setting the enable starts a frame at pixel 0, line 0.
- R11: The status word at address 7 holds vblank in bit 13, hblank in bit 12, the field in bit 10 (0 odd, 1 even) and the line count in bits 9..0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Combinational register or status read data |
| pix_in | input | 24 | Pixel colour shown inside the display window |
| hsync | output | 1 | Horizontal sync with programmed polarity |
| vsync | output | 1 | Vertical sync with programmed polarity |
| hblank | output | 1 | Pixel count outside the horizontal window |
| vblank | output | 1 | Line count outside the vertical window |
| rgb_out | output | 24 | Pixel, border colour, or black when disabled |
| line_irq | output | 1 | One-clock raster line interrupt pulse |

## Verification
The interrupt pulse and the field toggle can land in the same clock. This happens when a compare value is 0 and interlace is on, because the wrap to line 0 both flips the field and matches the compare. The bench provokes this by programming line A to 0 in interlaced, double-rate mode. It also shrinks the horizontal total while a line is in progress, so a wrap happens from a count above the total. A behavioural reference model tracks counters, field and interrupt and compares every output and the status word on every clock. Any disagreement about which of the two effects occurred in that clock is therefore reported.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_SCAN   = 2'd1,
        SEQ_REPEAT = 2'd2
    } seq_state_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_TOTAL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HWIN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_VWIN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_SYNCW  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IRQLN  = 3'd5;
    localparam logic [ADDR_W-1:0] A_COLOUR = 3'd6;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd7;

    localparam int CTRL_W = 7;

    typedef struct packed {
        logic line_rep;
        logic rate_dbl;
        logic blank_all;
        logic vs_high;
        logic hs_high;
        logic interlace;
        logic video_en;
    } ctrl_t;

    localparam int DEF_H_TOTAL = 857;
    localparam int DEF_V_TOTAL = 524;
    localparam int DEF_HW_BEG  = 126;
    localparam int DEF_HW_END  = 837;
    localparam int DEF_VW_BEG  = 40;
    localparam int DEF_VW_END  = 520;
    localparam int DEF_HS_WID  = 63;
    localparam int DEF_VS_WID  = 3;
    localparam int DEF_IRQ_A   = 21;
    localparam int DEF_IRQ_B   = 510;

    localparam int ST_VBLANK_BIT = 13;
    localparam int ST_HBLANK_BIT = 12;
    localparam int ST_FIELD_BIT  = 10;

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int HSW_W = 7,
    parameter int VSW_W = 4,
    parameter int COL_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       status_word,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  h_total,
    output logic [CNT_W-1:0]  v_total,
    output logic [CNT_W-1:0]  hw_beg,
    output logic [CNT_W-1:0]  hw_end,
    output logic [CNT_W-1:0]  vw_beg,
    output logic [CNT_W-1:0]  vw_end,
    output logic [HSW_W-1:0]  hs_wid,
    output logic [VSW_W-1:0]  vs_wid,
    output logic [CNT_W-1:0]  irq_a,
    output logic [CNT_W-1:0]  irq_b,
    output logic [COL_W-1:0]  colour,
    output logic [31:0]       rd_data
);

    localparam int HI = 16;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            h_total <= CNT_W'(DEF_H_TOTAL);
            v_total <= CNT_W'(DEF_V_TOTAL);
            hw_beg  <= CNT_W'(DEF_HW_BEG);
            hw_end  <= CNT_W'(DEF_HW_END);
            vw_beg  <= CNT_W'(DEF_VW_BEG);
            vw_end  <= CNT_W'(DEF_VW_END);
            hs_wid  <= HSW_W'(DEF_HS_WID);
            vs_wid  <= VSW_W'(DEF_VS_WID);
            irq_a   <= CNT_W'(DEF_IRQ_A);
            irq_b   <= CNT_W'(DEF_IRQ_B);
            colour  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:   ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                A_TOTAL: begin
                    h_total <= wr_data[CNT_W-1:0];
                    v_total <= wr_data[HI+CNT_W-1:HI];
                end
                A_HWIN: begin
                    hw_beg <= wr_data[CNT_W-1:0];
                    hw_end <= wr_data[HI+CNT_W-1:HI];
                end
                A_VWIN: begin
                    vw_beg <= wr_data[CNT_W-1:0];
                    vw_end <= wr_data[HI+CNT_W-1:HI];
                end
                A_SYNCW: begin
                    hs_wid <= wr_data[HSW_W-1:0];
                    vs_wid <= wr_data[8+VSW_W-1:8];
                end
                A_IRQLN: begin
                    irq_a <= wr_data[CNT_W-1:0];
                    irq_b <= wr_data[HI+CNT_W-1:HI];
                end
                A_COLOUR: colour <= wr_data[COL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:   rd_data[CTRL_W-1:0] = ctrl;
            A_TOTAL: begin
                rd_data[CNT_W-1:0]       = h_total;
                rd_data[HI+CNT_W-1:HI]   = v_total;
            end
            A_HWIN: begin
                rd_data[CNT_W-1:0]       = hw_beg;
                rd_data[HI+CNT_W-1:HI]   = hw_end;
            end
            A_VWIN: begin
                rd_data[CNT_W-1:0]       = vw_beg;
                rd_data[HI+CNT_W-1:HI]   = vw_end;
            end
            A_SYNCW: begin
                rd_data[HSW_W-1:0]       = hs_wid;
                rd_data[8+VSW_W-1:8]     = vs_wid;
            end
            A_IRQLN: begin
                rd_data[CNT_W-1:0]       = irq_a;
                rd_data[HI+CNT_W-1:HI]   = irq_b;
            end
            A_COLOUR: rd_data[COL_W-1:0] = colour;
            default:  rd_data            = status_word;
        endcase
    end

endmodule

// File: rtl/vtg_seq.sv
module vtg_seq
    import vtg_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             video_en,
    input  logic             interlace,
    input  logic             rate_dbl,
    input  logic             line_rep,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] v_total,
    input  logic [CNT_W-1:0] irq_a,
    input  logic [CNT_W-1:0] irq_b,
    output seq_state_t       state,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt,
    output logic             field,
    output logic             line_irq
);

    seq_state_t       state_nxt;
    logic             phase;
    logic             running;
    logic             step;
    logic             line_end;
    logic             advance;
    logic             frame_end;
    logic [CNT_W-1:0] v_next;

    assign running   = (state != SEQ_OFF);
    assign step      = rate_dbl | phase;
    assign line_end  = running && step && (h_cnt >= h_total);
    assign advance   = line_end && ((state == SEQ_REPEAT) || !line_rep);
    assign frame_end = advance && (v_cnt >= v_total);
    assign v_next    = frame_end ? '0 : v_cnt + 1'b1;

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_OFF: begin
                if (video_en) state_nxt = SEQ_SCAN;
            end
            SEQ_SCAN: begin
                if (!video_en)                state_nxt = SEQ_OFF;
                else if (line_end && line_rep) state_nxt = SEQ_REPEAT;
            end
            SEQ_REPEAT: begin
                if (!video_en)    state_nxt = SEQ_OFF;
                else if (line_end) state_nxt = SEQ_SCAN;
            end
            default: state_nxt = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_OFF;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cnt    <= '0;
            v_cnt    <= '0;
            phase    <= 1'b0;
            field    <= 1'b0;
            line_irq <= 1'b0;
        end else if (!video_en || !running) begin
            h_cnt    <= '0;
            v_cnt    <= '0;
            phase    <= 1'b0;
            field    <= 1'b0;
            line_irq <= 1'b0;
        end else begin
            phase    <= ~phase;
            line_irq <= 1'b0;
            if (step) h_cnt <= line_end ? '0 : h_cnt + 1'b1;
            if (advance) begin
                v_cnt    <= v_next;
                line_irq <= (v_next == irq_a) || (v_next == irq_b);
            end
            if (!interlace)     field <= 1'b0;
            else if (frame_end) field <= ~field;
        end
    end

endmodule

// File: rtl/vtg_out.sv
module vtg_out
    import vtg_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int HSW_W = 7,
    parameter int VSW_W = 4,
    parameter int COL_W = 24
) (
    input  seq_state_t       state,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] h_cnt,
    input  logic [CNT_W-1:0] v_cnt,
    input  logic [CNT_W-1:0] hw_beg,
    input  logic [CNT_W-1:0] hw_end,
    input  logic [CNT_W-1:0] vw_beg,
    input  logic [CNT_W-1:0] vw_end,
    input  logic [HSW_W-1:0] hs_wid,
    input  logic [VSW_W-1:0] vs_wid,
    input  logic [COL_W-1:0] colour,
    input  logic [COL_W-1:0] pix_in,
    output logic             hsync,
    output logic             vsync,
    output logic             hblank,
    output logic             vblank,
    output logic [COL_W-1:0] rgb_out
);

    logic hs_act;
    logic vs_act;
    logic border;

    assign hs_act = h_cnt < {{(CNT_W-HSW_W){1'b0}}, hs_wid};
    assign vs_act = v_cnt < {{(CNT_W-VSW_W){1'b0}}, vs_wid};
    assign hblank = !((h_cnt >= hw_beg) && (h_cnt < hw_end));
    assign vblank = !((v_cnt >= vw_beg) && (v_cnt < vw_end));
    assign border = hblank | vblank | ctrl.blank_all;

    always_comb begin
        unique case (state)
            SEQ_SCAN, SEQ_REPEAT: begin
                hsync   = hs_act ? ctrl.hs_high : ~ctrl.hs_high;
                vsync   = vs_act ? ctrl.vs_high : ~ctrl.vs_high;
                rgb_out = border ? colour : pix_in;
            end
            default: begin
                hsync   = ~ctrl.hs_high;
                vsync   = ~ctrl.vs_high;
                rgb_out = '0;
            end
        endcase
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int HSW_W = 7,
    parameter int VSW_W = 4,
    parameter int COL_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [COL_W-1:0]  pix_in,
    output logic              hsync,
    output logic              vsync,
    output logic              hblank,
    output logic              vblank,
    output logic [COL_W-1:0]  rgb_out,
    output logic              line_irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] h_total, v_total;
    logic [CNT_W-1:0] hw_beg, hw_end, vw_beg, vw_end;
    logic [HSW_W-1:0] hs_wid;
    logic [VSW_W-1:0] vs_wid;
    logic [CNT_W-1:0] irq_a, irq_b;
    logic [COL_W-1:0] colour;
    seq_state_t       seq_st;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic             field;
    logic [31:0]      status_word;

    always_comb begin
        status_word                = '0;
        status_word[ST_VBLANK_BIT] = vblank;
        status_word[ST_HBLANK_BIT] = hblank;
        status_word[ST_FIELD_BIT]  = field;
        status_word[CNT_W-1:0]     = v_cnt;
    end

    vtg_regs #(.CNT_W(CNT_W), .HSW_W(HSW_W), .VSW_W(VSW_W), .COL_W(COL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .status_word(status_word),
        .ctrl(ctrl), .h_total(h_total), .v_total(v_total),
        .hw_beg(hw_beg), .hw_end(hw_end), .vw_beg(vw_beg), .vw_end(vw_end),
        .hs_wid(hs_wid), .vs_wid(vs_wid), .irq_a(irq_a), .irq_b(irq_b),
        .colour(colour), .rd_data(rd_data)
    );

    vtg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .video_en(ctrl.video_en),
        .interlace(ctrl.interlace), .rate_dbl(ctrl.rate_dbl),
        .line_rep(ctrl.line_rep), .h_total(h_total), .v_total(v_total),
        .irq_a(irq_a), .irq_b(irq_b), .state(seq_st), .h_cnt(h_cnt),
        .v_cnt(v_cnt), .field(field), .line_irq(line_irq)
    );

    vtg_out #(.CNT_W(CNT_W), .HSW_W(HSW_W), .VSW_W(VSW_W), .COL_W(COL_W)) u_out (
        .state(seq_st), .ctrl(ctrl), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .hw_beg(hw_beg), .hw_end(hw_end), .vw_beg(vw_beg), .vw_end(vw_end),
        .hs_wid(hs_wid), .vs_wid(vs_wid), .colour(colour), .pix_in(pix_in),
        .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
        .rgb_out(rgb_out)
    );

endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
    import vtg_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int HSW_W = 7,
    parameter int COL_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input seq_state_t       st,
    input logic [CNT_W-1:0] h_cnt,
    input logic [CNT_W-1:0] v_cnt,
    input logic             field,
    input logic             interlace,
    input logic             hs_high,
    input logic             vs_high,
    input logic [HSW_W-1:0] hs_wid,
    input logic [CNT_W-1:0] irq_a,
    input logic [CNT_W-1:0] irq_b,
    input logic             hsync,
    input logic             vsync,
    input logic [COL_W-1:0] rgb_out,
    input logic             line_irq
);

    logic running;
    assign running = (st != SEQ_OFF);

    // R8: a pulse sits on pixel 0 of a line matching a compare value
    assert_irq_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq |-> (h_cnt == '0) &&
                     ((v_cnt == $past(irq_a)) || (v_cnt == $past(irq_b))));

    // R10: disabled state keeps syncs inactive and the pixel black
    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_OFF) |-> (rgb_out == '0) && (hsync == !hs_high) && (vsync == !vs_high));

    // R9: the field only changes where a frame restarts
    assert_field_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && $past(interlace) && (field != $past(field)))
            |-> (v_cnt == '0));

    // R2: the pixel count holds, steps by one, or wraps to zero
    assert_pixel_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running))
            |-> (h_cnt == $past(h_cnt)) || (h_cnt == $past(h_cnt) + 1'b1) || (h_cnt == '0));

    // R5: inside the pulse width the sync shows its active level
    assert_hsync_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (h_cnt < {{(CNT_W-HSW_W){1'b0}}, hs_wid})) |-> (hsync == hs_high));

endmodule

bind vtg_top vtg_chk #(.CNT_W(CNT_W), .HSW_W(HSW_W), .COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(seq_st), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .field(field), .interlace(ctrl.interlace), .hs_high(ctrl.hs_high),
    .vs_high(ctrl.vs_high), .hs_wid(hs_wid), .irq_a(irq_a), .irq_b(irq_b),
    .hsync(hsync), .vsync(vsync), .rgb_out(rgb_out), .line_irq(line_irq)
);

// File: tb/sim_vtg_top.sv
`timescale 1ns/1ps
module sim_vtg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd7;
    logic [31:0] rd_data;
    logic [23:0] pix_in = 24'h123456;
    logic        hsync, vsync, hblank, vblank, line_irq;
    logic [23:0] rgb_out;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;
    int irq_seen = 0;
    int field_hi_seen = 0;

    always #10 clk = ~clk;

    vtg_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pix_in(pix_in), .hsync(hsync), .vsync(vsync), .hblank(hblank),
        .vblank(vblank), .rgb_out(rgb_out), .line_irq(line_irq)
    );

    // reference model state
    logic [6:0]  m_ctrl;
    logic [9:0]  m_ht, m_vt, m_hb, m_he, m_vb, m_ve, m_ia, m_ib;
    logic [6:0]  m_hsw;
    logic [3:0]  m_vsw;
    logic [23:0] m_col;
    int          m_st;
    logic [9:0]  m_h, m_v;
    logic        m_ph, m_field, m_irq;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [2:0] a);
        logic [31:0] r = '0;
        logic hb, vb;
        hb = !((m_h >= m_hb) && (m_h < m_he));
        vb = !((m_v >= m_vb) && (m_v < m_ve));
        case (a)
            3'd0: r[6:0] = m_ctrl;
            3'd1: begin r[9:0] = m_ht; r[25:16] = m_vt; end
            3'd2: begin r[9:0] = m_hb; r[25:16] = m_he; end
            3'd3: begin r[9:0] = m_vb; r[25:16] = m_ve; end
            3'd4: begin r[6:0] = m_hsw; r[11:8] = m_vsw; end
            3'd5: begin r[9:0] = m_ia; r[25:16] = m_ib; end
            3'd6: r[23:0] = m_col;
            default: begin r[13] = vb; r[12] = hb; r[10] = m_field; r[9:0] = m_v; end
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_ht = 857; m_vt = 524; m_hb = 126; m_he = 837;
            m_vb = 40; m_ve = 520; m_hsw = 63; m_vsw = 3; m_ia = 21; m_ib = 510;
            m_col = '0; m_st = 0; m_h = '0; m_v = '0; m_ph = 0; m_field = 0; m_irq = 0;
        end else begin
            if (!m_ctrl[0] || m_st == 0) begin
                m_st = m_ctrl[0] ? 1 : 0;
                m_h = '0; m_v = '0; m_ph = 0; m_field = 0; m_irq = 0;
            end else begin
                bit step, lend, adv, fend;
                logic [9:0] nv;
                step = m_ctrl[5] || m_ph;
                m_ph = !m_ph;
                m_irq = 0;
                lend = 0;
                if (step) begin
                    if (m_h >= m_ht) begin m_h = '0; lend = 1; end
                    else m_h = m_h + 1'b1;
                end
                adv = lend && (m_st == 2 || !m_ctrl[6]);
                if (lend) m_st = (m_st == 1 && m_ctrl[6]) ? 2 : 1;
                fend = adv && (m_v >= m_vt);
                if (adv) begin
                    nv = fend ? 10'd0 : m_v + 1'b1;
                    m_irq = (nv == m_ia) || (nv == m_ib);
                    m_v = nv;
                end
                if (!m_ctrl[1]) m_field = 0;
                else if (fend) m_field = !m_field;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_ctrl = wr_data[6:0];
                    3'd1: begin m_ht = wr_data[9:0]; m_vt = wr_data[25:16]; end
                    3'd2: begin m_hb = wr_data[9:0]; m_he = wr_data[25:16]; end
                    3'd3: begin m_vb = wr_data[9:0]; m_ve = wr_data[25:16]; end
                    3'd4: begin m_hsw = wr_data[6:0]; m_vsw = wr_data[11:8]; end
                    3'd5: begin m_ia = wr_data[9:0]; m_ib = wr_data[25:16]; end
                    3'd6: m_col = wr_data[23:0];
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(posedge clk) begin
        #5;
        if (started && !done) begin
            bit off, hsa, vsa, hb, vb;
            logic [23:0] exp_rgb;
            off = (m_st == 0);
            hsa = m_h < {3'b0, m_hsw};
            vsa = m_v < {6'b0, m_vsw};
            hb = !((m_h >= m_hb) && (m_h < m_he));
            vb = !((m_v >= m_vb) && (m_v < m_ve));
            exp_rgb = off ? 24'h0 : ((hb || vb || m_ctrl[4]) ? m_col : pix_in);
            chk("R5 hsync", {31'b0, hsync}, {31'b0, off ? !m_ctrl[2] : (hsa ? m_ctrl[2] : !m_ctrl[2])});
            chk("R5 vsync", {31'b0, vsync}, {31'b0, off ? !m_ctrl[3] : (vsa ? m_ctrl[3] : !m_ctrl[3])});
            chk("R6 blank flags", {30'b0, hblank, vblank}, {30'b0, hb, vb});
            chk("R6 R7 R10 rgb", {8'b0, rgb_out}, {8'b0, exp_rgb});
            chk("R8 line_irq", {31'b0, line_irq}, {31'b0, m_irq});
            chk("R11 R2 R3 R4 R9 read", rd_data, m_read(rd_addr));
            if (line_irq) irq_seen++;
            if (rd_addr == 3'd7 && rd_data[10]) field_hi_seen++;
        end
    end

    always @(negedge clk) pix_in <= pix_in + 24'h010203;

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
        rd_addr = 3'd7;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R10 and R11
        chk("R10 reset hsync idle", {31'b0, hsync}, 32'd1);
        chk("R10 reset rgb black", {8'b0, rgb_out}, 32'd0);
        chk("R8 reset irq low", {31'b0, line_irq}, 32'd0);
        rst_n = 1'b1;
        rd_chk("R1 default totals", 3'd1, (32'd524 << 16) | 32'd857);
        rd_chk("R1 default irq lines", 3'd5, (32'd510 << 16) | 32'd21);
        rd_chk("R11 status after reset", 3'd7, 32'h0000_3000);
        started = 1;

        wr(3'd1, (32'd5 << 16) | 32'd9);
        wr(3'd2, (32'd8 << 16) | 32'd2);
        wr(3'd3, (32'd4 << 16) | 32'd1);
        wr(3'd4, (32'd1 << 8) | 32'd2);
        wr(3'd5, (32'd3 << 16) | 32'd0);
        wr(3'd6, 32'hFF00_AA55);
        rd_chk("R1 totals readback", 3'd1, (32'd5 << 16) | 32'd9);
        rd_chk("R1 sync width readback", 3'd4, 32'h0000_0102);
        rd_chk("R1 colour upper bits dropped", 3'd6, 32'h0000_AA55);

        // progressive, normal rate
        irq_seen = 0; field_hi_seen = 0;
        wr(3'd0, 32'h01);
        repeat (300) @(negedge clk);
        chk("R8 pulses in progressive run", {31'b0, irq_seen > 0}, 32'd1);
        chk("R9 field stays 0 progressive", field_hi_seen, 32'd0);

        // interlace, doubled rate, irq at line 0 coincides with field flip
        field_hi_seen = 0;
        wr(3'd0, 32'h23);
        repeat (300) @(negedge clk);
        chk("R9 field reached 1 in interlace", {31'b0, field_hi_seen > 0}, 32'd1);

        // line repeat with active-high syncs
        wr(3'd0, 32'h4D);
        repeat (400) @(negedge clk);

        // blank-all
        wr(3'd0, 32'h11);
        repeat (150) @(negedge clk);
        chk("R7 blank-all shows colour", {8'b0, rgb_out}, 32'h0000_AA55);

        // compare values above the frame
        wr(3'd5, (32'd30 << 16) | 32'd20);
        irq_seen = 0;
        wr(3'd0, 32'h21);
        repeat (300) @(negedge clk);
        chk("R8 no pulse beyond total", irq_seen, 32'd0);

        // shrink the line while running (count above total wraps)
        wr(3'd5, (32'd2 << 16) | 32'd1);
        wr(3'd0, 32'h01);
        repeat (15) @(negedge clk);
        wr(3'd1, (32'd5 << 16) | 32'd3);
        repeat (200) @(negedge clk);

        // disable
        wr(3'd0, 32'h00);
        repeat (5) @(negedge clk);
        chk("R10 disabled rgb black", {8'b0, rgb_out}, 32'd0);
        chk("R10 disabled hsync idle", {31'b0, hsync}, 32'd1);
        rd_chk("R10 disabled line zero", 3'd7, m_read(3'd7));
        wr(3'd0, 32'h01);
        repeat (100) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule